// File: doc/BRIEF.md
# Word-Encoded Instruction Execute Unit

This block takes one 32-bit instruction word per clock, decodes it, and executes it against a register file of 32 entries, each 32 bits wide. It covers a small integer subset: register-register add and signed set-less-than, add with a signed 16-bit constant, signed set-less-than against a 16-bit constant, and load of a 16-bit constant into the upper half of a register. Two instruction shapes are recognised. The register shape names two sources and a destination, and a function code selects the operation. The immediate shape names one source and a destination and carries a 16-bit constant.

An instruction is presented together with a valid strobe. The result is written into the register file at the clock edge that ends the presenting cycle, so the next instruction can already read it. Two observation read ports let the surrounding logic or a testbench read any register. A flag reports, in the same cycle, any word whose operation code or function code is not one of the supported ones. Such a word leaves every register unchanged.

Top module: `isx_exec_unit`

## Requirements
- R1: Word fields are opcode=[31:26], first source=[25:21], second field=[20:16], register-shape destination=[15:11], function=[5:0], constant=[15:0]. Opcode 0 with function 32 writes first source + second source, wrapped modulo 2^32 with no trap, to the register named in [15:11].
- R2: Opcode 0 with function 42 writes 1 to [15:11] when the first source is less than the second as signed 32-bit numbers, and writes 0 otherwise.
- R3: Opcode 8 writes the first source plus the sign-extended constant, modulo 2^32, to the register named in [20:16]. Field [15:11] is not used as a destination.
- R4: Opcode 10 writes 1 to [20:16] when the first source is less than the sign-extended constant as signed numbers, and writes 0 otherwise.
- R5: Opcode 15 writes the constant into bits 31:16 of register [20:16] and writes zeros into bits 15:0.
- R6: Register 0 always reads as zero on every port, and writes that name it are dropped.
- R7: A valid word with any other opcode, or with opcode 0 and a function other than 32 or 42, raises the illegal flag in that same cycle and changes no register.
- R8: While valid is low the illegal flag is low and no register changes, whatever the word holds.
- R9: A result is visible on the observation ports one cycle after its instruction, and an instruction presented in that next cycle reads the new value as its source.
- R10: Reset, active low, clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | The word on instr_word is to be executed this cycle |
| instr_word | input | 32 | Instruction word |
| obs_addr_a | input | 5 | Register number for observation port A |
| obs_data_a | output | 32 | Contents of the register selected on port A |
| obs_addr_b | input | 5 | Register number for observation port B |
| obs_data_b | output | 32 | Contents of the register selected on port B |
| illegal_o | output | 1 | The valid word this cycle holds an unsupported opcode or function |

## Verification
Operands are first built with constant-add instructions so that both signs occur. The two comparisons are then tried with a negative value against a positive one, with both values negative, and with both orders of operands, which separates a signed compare from an unsigned one. A constant-add with the sign bit set, together with a register add whose sum passes 2^32, exposes missing sign extension or a width slip. Words aimed at register 0, words with an unknown function or opcode, and words held while valid is low are each followed by a read of the register they could have touched. A dependent pair presented in consecutive cycles shows that the write lands before the next read.

// File: rtl/isx_pkg.sv
package isx_pkg;

  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int IMM_W  = 16;

  // operation codes carried in bits 31:26
  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_ADDI = 6'd8;
  localparam logic [5:0] OPC_SLTI = 6'd10;
  localparam logic [5:0] OPC_LUI  = 6'd15;

  // function codes carried in bits 5:0 when the opcode is OPC_REG
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_ADD  = 2'd1,
    K_SLT  = 2'd2,
    K_LUI  = 2'd3
  } kind_e;

  typedef enum logic {
    B_REG = 1'b0,
    B_IMM = 1'b1
  } bsel_e;

  typedef struct packed {
    logic              legal;
    kind_e             kind;
    bsel_e             bsel;
    logic [REG_AW-1:0] src_a;
    logic [REG_AW-1:0] src_b;
    logic [REG_AW-1:0] dst;
    logic [IMM_W-1:0]  imm;
  } dec_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] add_wrap(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  function automatic logic [XLEN-1:0] lt_signed(input logic [XLEN-1:0] a,
                                                input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    r = '0;
    r[0] = ($signed(a) < $signed(b));
    return r;
  endfunction

  function automatic logic [XLEN-1:0] upper_load(input logic [IMM_W-1:0] v);
    return {v, {(XLEN-IMM_W){1'b0}}};
  endfunction

endpackage

// File: rtl/isx_decode.sv
module isx_decode
  import isx_pkg::*;
(
  input  logic [31:0] word,
  output dec_t        dec
);

  logic [5:0] opc;
  logic [5:0] fn;
  logic       unused_shamt;

  assign opc          = word[31:26];
  assign fn           = word[5:0];
  assign unused_shamt = ^word[10:6];

  always_comb begin
    dec.legal = 1'b0;
    dec.kind  = K_NONE;
    dec.bsel  = B_IMM;
    dec.src_a = word[25:21];
    dec.src_b = word[20:16];
    dec.dst   = word[20:16];
    dec.imm   = word[15:0];
    unique case (opc)
      OPC_REG: begin
        dec.bsel = B_REG;
        dec.dst  = word[15:11];
        if (fn == FN_ADD) begin
          dec.legal = 1'b1;
          dec.kind  = K_ADD;
        end else if (fn == FN_SLT) begin
          dec.legal = 1'b1;
          dec.kind  = K_SLT;
        end
      end
      OPC_ADDI: begin
        dec.legal = 1'b1;
        dec.kind  = K_ADD;
      end
      OPC_SLTI: begin
        dec.legal = 1'b1;
        dec.kind  = K_SLT;
      end
      OPC_LUI: begin
        dec.legal = 1'b1;
        dec.kind  = K_LUI;
      end
      default: begin
        dec.legal = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/isx_alu.sv
module isx_alu
  import isx_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  kind_e            kind,
  input  bsel_e            bsel,
  input  logic [DW-1:0]    opa,
  input  logic [DW-1:0]    opb_reg,
  input  logic [IMM_W-1:0] imm,
  output logic [DW-1:0]    result
);

  logic [DW-1:0] opb;

  assign opb = (bsel == B_IMM) ? sext_imm(imm) : opb_reg;

  always_comb begin
    unique case (kind)
      K_ADD:   result = add_wrap(opa, opb);
      K_SLT:   result = lt_signed(opa, opb);
      K_LUI:   result = upper_load(imm);
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/isx_regfile.sv
module isx_regfile #(
  parameter int DW  = 32,
  parameter int AW  = 5,
  parameter int NRD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr [NRD],
  output logic [DW-1:0] rdata [NRD]
);

  localparam int NREG = 1 << AW;

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we && (waddr != '0)) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : mem[raddr[p]];
  end

endmodule

// File: rtl/isx_exec_unit.sv
module isx_exec_unit
  import isx_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [31:0]   instr_word,
  input  logic [AW-1:0] obs_addr_a,
  output logic [DW-1:0] obs_data_a,
  input  logic [AW-1:0] obs_addr_b,
  output logic [DW-1:0] obs_data_b,
  output logic          illegal_o
);

  localparam int NRD    = 4;
  localparam int P_SRCA = 0;
  localparam int P_SRCB = 1;
  localparam int P_OBSA = 2;
  localparam int P_OBSB = 3;

  dec_t          dec;
  logic [AW-1:0] raddr [NRD];
  logic [DW-1:0] rdata [NRD];
  logic [DW-1:0] alu_out;

  // named internal events, used by the checker
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  isx_decode u_dec (
    .word (instr_word),
    .dec  (dec)
  );

  assign raddr[P_SRCA] = dec.src_a;
  assign raddr[P_SRCB] = dec.src_b;
  assign raddr[P_OBSA] = obs_addr_a;
  assign raddr[P_OBSB] = obs_addr_b;

  isx_alu #(.DW(DW)) u_alu (
    .kind    (dec.kind),
    .bsel    (dec.bsel),
    .opa     (rdata[P_SRCA]),
    .opb_reg (rdata[P_SRCB]),
    .imm     (dec.imm),
    .result  (alu_out)
  );

  assign wr_en   = instr_valid && dec.legal && (dec.dst != '0);
  assign wr_addr = dec.dst;
  assign wr_data = alu_out;

  isx_regfile #(.DW(DW), .AW(AW), .NRD(NRD)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign obs_data_a = rdata[P_OBSA];
  assign obs_data_b = rdata[P_OBSB];
  assign illegal_o  = instr_valid && !dec.legal;

endmodule

// File: rtl/isx_exec_checker.sv
module isx_exec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic [31:0] instr_word,
  input logic [4:0]  obs_addr_a,
  input logic [31:0] obs_data_a,
  input logic        illegal_o,
  input logic        wr_en,
  input logic [4:0]  wr_addr,
  input logic [31:0] wr_data
);

  logic [5:0] opc;
  logic       known_opc;
  assign opc       = instr_word[31:26];
  assign known_opc = (opc == 6'd0) || (opc == 6'd8) || (opc == 6'd10) || (opc == 6'd15);

  // R6: register 0 reads as zero
  a_r6_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_addr_a == 5'd0) |-> (obs_data_a == 32'd0));

  // R7: unknown opcode raises the flag
  a_r7_flag_on_bad_opc: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !known_opc) |-> illegal_o);

  // R7: a flagged word leaves the observed register alone
  a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o ##1 $stable(obs_addr_a) |-> $stable(obs_data_a));

  // R8: idle cycles keep the flag low
  a_r8_idle_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !illegal_o);

  // R8: idle cycles change no register
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid ##1 $stable(obs_addr_a) |-> $stable(obs_data_a));

  // R5: upper load shape
  a_r5_upper_load: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && opc == 6'd15 && instr_word[20:16] != 5'd0 &&
     obs_addr_a == instr_word[20:16]) ##1 $stable(obs_addr_a)
    |-> (obs_data_a == {$past(instr_word[15:0]), 16'h0000}));

  // R9: the written value shows on the next cycle
  a_r9_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == obs_addr_a) ##1 $stable(obs_addr_a)
    |-> (obs_data_a == $past(wr_data)));

  // R6: no write is ever issued to register 0
  a_r6_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr != 5'd0));

endmodule

bind isx_exec_unit isx_exec_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_word  (instr_word),
  .obs_addr_a  (obs_addr_a),
  .obs_data_a  (obs_data_a),
  .illegal_o   (illegal_o),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data)
);

// File: tb/tb_isx_exec_unit.sv
module tb_isx_exec_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [4:0]  obs_addr_a = '0;
  logic [4:0]  obs_addr_b = '0;
  logic [31:0] obs_data_a;
  logic [31:0] obs_data_b;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  isx_exec_unit dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .obs_addr_a  (obs_addr_a),
    .obs_data_a  (obs_data_a),
    .obs_addr_b  (obs_addr_b),
    .obs_data_b  (obs_data_b),
    .illegal_o   (illegal_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {word, observed register, expected value, expected flag, tag}
  typedef struct packed {
    logic [31:0] word;
    logic [4:0]  rg;
    logic [31:0] exp;
    logic        ill;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{32'h20010064, 5'd1,  32'h00000064, 1'b0}, // R3 r1 = 100
    '{32'h2002FFCE, 5'd2,  32'hFFFFFFCE, 1'b0}, // R3 r2 = -50
    '{32'h00221820, 5'd3,  32'h00000032, 1'b0}, // R1 r3 = r1 + r2
    '{32'h0041202A, 5'd4,  32'h00000001, 1'b0}, // R2 -50 < 100
    '{32'h0022282A, 5'd5,  32'h00000000, 1'b0}, // R2 100 < -50 false
    '{32'h3C06ABAB, 5'd6,  32'hABAB0000, 1'b0}, // R5 upper load
    '{32'h2847FFCF, 5'd7,  32'h00000001, 1'b0}, // R4 -50 < -49
    '{32'h2828FFFF, 5'd8,  32'h00000000, 1'b0}, // R4 100 < -1 false
    '{32'h3C097FFF, 5'd9,  32'h7FFF0000, 1'b0}, // R5 upper load positive
    '{32'h00C65820, 5'd11, 32'h57560000, 1'b0}, // R1 sum wraps
    '{32'h00C9602A, 5'd12, 32'h00000001, 1'b0}, // R2 negative < positive
    '{32'h20200005, 5'd0,  32'h00000000, 1'b0}, // R6 write to r0 dropped
    '{32'h00420821, 5'd1,  32'h00000064, 1'b1}, // R7 bad function, r1 kept
    '{32'h8C011234, 5'd1,  32'h00000064, 1'b1}, // R7 bad opcode, r1 kept
    '{32'h202D7FFF, 5'd13, 32'h00008063, 1'b0}, // R3 largest positive constant
    '{32'h21AE0001, 5'd14, 32'h00008064, 1'b0}  // R9 reads r13 of the prior cycle
  };

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R10: reset clears everything
    for (int r = 0; r < 32; r++) begin
      obs_addr_a = 5'(r);
      #1 chk("R10 reset value", obs_data_a, 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R8 flag low when idle", {31'd0, illegal_o}, 32'd0);

    // vector walk, one instruction per cycle, back to back
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      instr_word  = VEC[v].word;
      instr_valid = 1'b1;
      obs_addr_a  = VEC[v].rg;
      #1 chk($sformatf("R7 flag vec %0d", v), {31'd0, illegal_o}, {31'd0, VEC[v].ill});
      @(negedge clk);
      #1 chk($sformatf("R1-R9 table vec %0d", v), obs_data_a, VEC[v].exp);
    end
    instr_valid = 1'b0;

    // R3: constant-add destination is [20:16], not [15:11]
    obs_addr_a = 5'd1;   // rd field of 0x202D7FFF is 15 (0x7FFF>>11)
    obs_addr_b = 5'd15;
    #1 chk("R3 rd field untouched", obs_data_b, 32'd0);
    chk("R3 source kept", obs_data_a, 32'h64);

    // R8: valid low, word would write r1 = 7
    instr_word = 32'h20010007;
    #1 chk("R8 flag with valid low", {31'd0, illegal_o}, 32'd0);
    @(negedge clk);
    #1 chk("R8 r1 unchanged", obs_data_a, 32'h64);

    // R6: port B of register 0 after a write naming it
    obs_addr_b = 5'd0;
    #1 chk("R6 port B r0", obs_data_b, 32'd0);
    obs_addr_b = 5'd6;
    #1 chk("R9 port B sees r6", obs_data_b, 32'hABAB0000);

    // R10: reset in mid-run
    rst_n = 1'b0;
    obs_addr_a = 5'd3;
    @(negedge clk);
    #1 chk("R10 r3 after reset", obs_data_a, 32'd0);
    chk("R10 r6 after reset", obs_data_b, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule